// File: doc/BRIEF.md
# Pulse-width ternary symbol classifier

This block turns a one-bit time-code input into a stream of classified symbols. The input is already level-shifted to digital logic, is sampled by a 10 kHz system clock, and carries one symbol per second. A falling edge of the input opens a symbol. The time the input then spends high decides which of three symbol kinds was sent: a long high period, a medium one or a short one.

Short spurious pulses are removed first. After that, an edge-driven flag state machine arms a high-time counter on the rising edge that follows each symbol start. The count is compared against four fixed boundaries when the falling edge closes the high period. The result is latched as a two-bit code and announced by a one-cycle valid strobe. A downstream frame aligner reads symbols only on that strobe.

Top module: `pwm_symbol_classifier`

## Requirements
- R1: While `rst_ni` is low and after its release, `sym_valid_o` is 0 and `sym_code_o` is 2'b11 until the first symbol is classified.
- R2: For a filtered high period of H clock cycles, the code is 2'b00 (zero) when 6500 <= H <= 9500, 2'b01 (one) when 3500 <= H <= 6499, and 2'b10 (marker) when 1000 <= H <= 3499.
- R3: A high period with H < 1000 or H > 9500 gives code 2'b11 (invalid), and no other class.
- R4: Each high period that is closed by a falling edge gives exactly one strobe on `sym_valid_o`, high for one cycle. `sym_code_o` keeps its value between strobes.
- R5: A raw input level lasting fewer than 16 consecutive clock cycles has no effect. A level lasting 16 cycles or more is accepted, and the measured H equals the raw high duration.
- R6: A low glitch shorter than 16 cycles inside a high period does not split it. The cycles of the glitch count toward H.
- R7: After reset, a high period that was not preceded by a falling edge produces no strobe.
- R8: The high-time count saturates, so a high period of any length above 9500 cycles (for example 12000) is reported as invalid.
- R9: When the raw input falls just before clock edge 1, `sym_valid_o` is high in the cycle after clock edge 19. This is a fixed latency of 16 + 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System and sampling clock (10 kHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tc_i | input | 1 | Raw time-code level, asynchronous to `clk_i` |
| sym_valid_o | output | 1 | One-cycle strobe: a new symbol has been classified |
| sym_code_o | output | 2 | Symbol code: 00 zero, 01 one, 10 marker, 11 invalid |

## Verification
Two functions can land in one cycle. The counter can reach its saturation ceiling in the very cycle in which the falling edge ends the high period. The filter can also accept a new level in the cycle where a glitch is just long enough to count. High periods of 9500 and 9501 cycles place the ceiling exactly on the closing edge, and 15- and 16-cycle pulses sit on the two sides of the filter's acceptance point. Each result is judged by the code and the latency of the single strobe, against a classification computed in the bench from H.

// File: rtl/pwm_sym_pkg.sv
package pwm_sym_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_MARK = 2'b10,
    SYM_BAD  = 2'b11
  } sym_code_e;

  typedef enum logic [1:0] {
    FL_ARM  = 2'b00,
    FL_LOW  = 2'b01,
    FL_HIGH = 2'b10
  } flag_state_e;

endpackage

// File: rtl/tc_glitch_filter.sv
module tc_glitch_filter #(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);

  localparam int unsigned StbW = $clog2(STABLE_CYCLES + 1);
  localparam logic [StbW-1:0] StbLast = StbW'(STABLE_CYCLES - 1);

  logic            sync_q1, sync_q2;
  logic [StbW-1:0] stb_cnt_q;
  logic            level_q;

  // two-flop synchronizer, input is asynchronous to clk_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= raw_i;
      sync_q2 <= sync_q1;
    end
  end

  // accept a new level only after STABLE_CYCLES differing samples in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_cnt_q <= '0;
      level_q   <= 1'b0;
    end else if (sync_q2 == level_q) begin
      stb_cnt_q <= '0;
    end else if (stb_cnt_q == StbLast) begin
      stb_cnt_q <= '0;
      level_q   <= sync_q2;
    end else begin
      stb_cnt_q <= stb_cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

  assert_level_settled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(stb_cnt_q) == StbLast && $past(sync_q2) == level_q));

endmodule

// File: rtl/tc_edge_flag_fsm.sv
module tc_edge_flag_fsm
  import pwm_sym_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic start_o,
  output logic end_o,
  output logic in_high_o
);

  flag_state_e state_q, state_d;
  logic        level_q;
  logic        rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise = level_i & ~level_q;
  assign fall = ~level_i & level_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FL_ARM:  if (fall) state_d = FL_LOW;
      FL_LOW:  if (rise) state_d = FL_HIGH;
      FL_HIGH: if (fall) state_d = FL_LOW;
      default: state_d = FL_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FL_ARM;
    else         state_q <= state_d;
  end

  assign start_o   = (state_q == FL_LOW) & rise;
  assign end_o     = (state_q == FL_HIGH) & fall;
  assign in_high_o = (state_q == FL_HIGH);

  assert_high_via_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == FL_HIGH) |-> ($past(state_q) == FL_LOW));

  assert_end_returns_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> (state_q == FL_LOW && !level_i));

endmodule

// File: rtl/tc_high_counter.sv
module tc_high_counter #(
  parameter int unsigned MAX_HIGH = 9500
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic                               in_high_i,
  input  logic                               level_i,
  output logic [$clog2(MAX_HIGH + 2)-1:0]    cnt_o
);

  localparam int unsigned CntW = $clog2(MAX_HIGH + 2);
  localparam logic [CntW-1:0] Ceil = CntW'(MAX_HIGH + 1);

  logic [CntW-1:0] cnt_q;

  // cnt_q equals high cycles seen so far; stops one past the valid range
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CntW'(1);
    end else if (in_high_i && level_i && cnt_q != Ceil) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_cnt_ceiling_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Ceil);

  assert_cnt_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CntW'(1)));

endmodule

// File: rtl/tc_symbol_decide.sv
module tc_symbol_decide
  import pwm_sym_pkg::*;
#(
  parameter int unsigned MIN_HIGH = 1000,
  parameter int unsigned MARK_MAX = 3500,
  parameter int unsigned ONE_MAX  = 6500,
  parameter int unsigned MAX_HIGH = 9500
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            end_i,
  input  logic [$clog2(MAX_HIGH + 2)-1:0] cnt_i,
  output logic                            valid_o,
  output logic [1:0]                      code_o
);

  localparam int unsigned CntW = $clog2(MAX_HIGH + 2);

  sym_code_e code_d, code_q;
  logic      valid_q;

  always_comb begin
    if (cnt_i < CntW'(MIN_HIGH) || cnt_i > CntW'(MAX_HIGH)) code_d = SYM_BAD;
    else if (cnt_i < CntW'(MARK_MAX))                       code_d = SYM_MARK;
    else if (cnt_i < CntW'(ONE_MAX))                        code_d = SYM_ONE;
    else                                                    code_d = SYM_ZERO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= SYM_BAD;
    end else begin
      valid_q <= end_i;
      if (end_i) code_q <= code_d;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  assert_code_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(code_q));

  assert_strobe_follows_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(end_i));

endmodule

// File: rtl/pwm_symbol_classifier.sv
module pwm_symbol_classifier #(
  parameter int unsigned STABLE_CYCLES = 16,
  parameter int unsigned MIN_HIGH      = 1000,
  parameter int unsigned MARK_MAX      = 3500,
  parameter int unsigned ONE_MAX       = 6500,
  parameter int unsigned MAX_HIGH      = 9500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tc_i,
  output logic       sym_valid_o,
  output logic [1:0] sym_code_o
);

  localparam int unsigned CntW = $clog2(MAX_HIGH + 2);

  logic            level;
  logic            start, sym_end, in_high;
  logic [CntW-1:0] high_cnt;

  tc_glitch_filter #(.STABLE_CYCLES(STABLE_CYCLES)) i_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (tc_i),
    .level_o (level)
  );

  tc_edge_flag_fsm i_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .start_o   (start),
    .end_o     (sym_end),
    .in_high_o (in_high)
  );

  tc_high_counter #(.MAX_HIGH(MAX_HIGH)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .in_high_i (in_high),
    .level_i   (level),
    .cnt_o     (high_cnt)
  );

  tc_symbol_decide #(
    .MIN_HIGH (MIN_HIGH),
    .MARK_MAX (MARK_MAX),
    .ONE_MAX  (ONE_MAX),
    .MAX_HIGH (MAX_HIGH)
  ) i_decide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .end_i   (sym_end),
    .cnt_i   (high_cnt),
    .valid_o (sym_valid_o),
    .code_o  (sym_code_o)
  );

  assert_bad_code_bounds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && $past(high_cnt) > CntW'(MAX_HIGH)) |-> (sym_code_o == 2'b11));

endmodule

// File: tb/test_pwm_symbol_classifier.sv
module test_pwm_symbol_classifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tc = 1'b0;
  logic       valid;
  logic [1:0] code;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int n_strobe = 0;
  int last_t   = 0;
  logic [1:0] last_code = 2'b11;

  always #10 clk = ~clk;

  pwm_symbol_classifier i_pwm_symbol_classifier (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tc_i        (tc),
    .sym_valid_o (valid),
    .sym_code_o  (code)
  );

  function automatic logic [1:0] expect_code(int h);
    if (h < 1000 || h > 9500) return 2'b11;
    if (h < 3500)             return 2'b10;
    if (h < 6500)             return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (valid) begin
      n_strobe++;
      last_code = code;
      last_t    = cyc;
    end
  endtask

  task automatic drive(logic lvl, int n);
    tc = lvl;
    repeat (n) tick();
  endtask

  // high for h cycles, then low; expect one strobe with class of h, latency 19
  task automatic send_high(int h, string req);
    int s0, tf;
    s0 = n_strobe;
    drive(1'b1, h);
    tf = cyc;
    drive(1'b0, 60);
    check(n_strobe == s0 + 1, req, n_strobe - s0, 1);
    check(last_code == expect_code(h), req, last_code, expect_code(h));
    check(last_t - tf == 19, {req, "/R9"}, last_t - tf, 19);
  endtask

  task automatic t_reset();
    check(valid == 1'b0, "R1", valid, 0);
    check(code == 2'b11, "R1", code, 3);
  endtask

  task automatic t_unarmed();
    int s0;
    s0 = n_strobe;
    drive(1'b1, 5000);
    drive(1'b0, 60);
    check(n_strobe == s0, "R7", n_strobe - s0, 0);
    check(code == 2'b11, "R7", code, 3);
  endtask

  task automatic t_classes();
    send_high(8000, "R2");
    send_high(5000, "R2");
    send_high(2000, "R2");
    send_high(1000, "R2");
    send_high(3499, "R2");
    send_high(3500, "R2");
    send_high(6499, "R2");
    send_high(6500, "R2");
    send_high(9500, "R2");
  endtask

  task automatic t_invalid();
    send_high(999, "R3");
    send_high(9501, "R3");
    send_high(12000, "R8");
  endtask

  task automatic t_hold();
    logic [1:0] c0;
    int s0;
    send_high(5000, "R4");
    c0 = code;
    s0 = n_strobe;
    drive(1'b0, 300);
    check(n_strobe == s0, "R4", n_strobe - s0, 0);
    check(code == c0, "R4", code, c0);
    check(valid == 1'b0, "R4", valid, 0);
  endtask

  task automatic t_filter();
    int s0;
    s0 = n_strobe;
    drive(1'b1, 15);
    drive(1'b0, 60);
    check(n_strobe == s0, "R5", n_strobe - s0, 0);
    check(code == 2'b01, "R5", code, 1);
    send_high(16, "R5");
  endtask

  task automatic t_inner_glitch();
    int s0;
    s0 = n_strobe;
    drive(1'b1, 4000);
    drive(1'b0, 15);
    drive(1'b1, 3000);
    drive(1'b0, 60);
    check(n_strobe == s0 + 1, "R6", n_strobe - s0, 1);
    check(last_code == expect_code(7015), "R6", last_code, expect_code(7015));
    send_high(2500, "R6");
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    drive(1'b0, 40);
    t_reset();
    t_unarmed();
    t_classes();
    t_invalid();
    t_hold();
    t_filter();
    t_inner_glitch();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule